// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor timer of a local interrupt controller. A free-running timestamp advances on every clock. Software programs three things through a small register port: a timer entry (vector, mask and mode), an initial count, and a divide code that selects a power-of-two prescale shift. Writing the initial count records the current timestamp as the load time and arms the timer.

Elapsed ticks are the timestamp distance from the load time, shifted right by the prescale shift. The timer does not count down. It compares elapsed ticks against a stored next-expiry tick. In periodic mode that tick moves forward by (count + 1) on every expiry, so the expiries stay on a fixed grid anchored at the load time. In one-shot mode the timer expires once and then disarms. Each expiry raises a one-cycle request pulse that carries the programmed vector, unless the entry is masked at that moment. A readable current count reports how much of the present period is left.

Top module: `lict_timer`

## Requirements
- R1: After reset, address 0 reads 0x0001_0000 (mask bit 16 set, vector 0, periodic bit 17 clear). Addresses 1, 2 and 3 read 0. No pulse is raised, and the prescale shift is 0 (divide by 1) until the divide register is written.
- R2: The divide code at address 3 forms a value v from its bits {3,1,0}, and the shift is (v+1) mod 8. Code 4'b1011 divides by 1, 4'b0001 by 4, 4'b0010 by 8 and 4'b1010 by 128. The pulse spacing is (N+1)·2^shift cycles for initial count N.
- R3: While entry bit 16 (mask) is set in the cycle an expiry is detected, no pulse appears. A periodic timer keeps its grid while masked, and after unmasking it pulses again on the original grid.
- R4: An initial count of 0 never produces a pulse, in periodic or one-shot mode.
- R5: In periodic mode (entry bit 17 = 1), let c0 be the cycle right after the edge that takes the initial-count write, and P = (N+1)·2^shift. Then irq_valid is high for exactly one cycle at cycles c0+k·P for k = 1, 2, …, with irq_vector equal to entry bits 7:0.
- R6: In one-shot mode (bit 17 = 0), a single pulse appears at c0+P and none after it. Once expired, the current count reads 0.
- R7: The current count (address 2) reads N − ((j+1) >> shift) in the cycle j clock edges after the write edge, within the first period.
- R8: Rewriting the initial count discards the old schedule and restarts timing from the new write edge with the new count.
- R9: If the write edge of an initial-count write coincides with the edge that would register a pulse, that pulse is suppressed and the timer restarts from the write.
- R10: Address map: 0 timer entry, 1 initial count, 2 current count (read-only, writes ignored), 3 divide code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also advances the timestamp |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | VEC_W | Vector sent with the request |

## Verification
An expiry being registered and a rewrite of the initial count can land on the same clock edge. The bench provokes this by placing the rewrite of a running periodic timer so that its write edge is exactly the edge where the first pulse would be registered. It then expects that pulse to be missing and the next pulses to sit on the grid of the new count measured from the rewrite. A scoreboard holds the expected pulse cycles and vectors. Any pulse that is not in the queue, and any expected pulse left in the queue, is reported.

// File: rtl/lict_pkg.sv
package lict_pkg;

   // register addresses; order is visible to software
   typedef enum logic [1:0] {
      REG_ENTRY = 2'd0,
      REG_INIT  = 2'd1,
      REG_CUR   = 2'd2,
      REG_DIV   = 2'd3
   } lict_reg_e;

   localparam int ENTRY_MASK_BIT = 16;
   localparam int ENTRY_PER_BIT  = 17;
   localparam int SHIFT_W        = 3;
   localparam int DIV_W          = 4;

   // divide code bits {3,1,0} plus one, modulo eight, give the shift
   function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] code);
      logic [SHIFT_W-1:0] v;
      v = {code[3], code[1], code[0]};
      return v + 3'd1;
   endfunction

endpackage

// File: rtl/lict_timebase.sv
module lict_timebase #(
   parameter int TS_W = 48
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] now
);
   logic [TS_W-1:0] now_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + TS_W'(1);
   end

   assign now = now_q;
endmodule

// File: rtl/lict_regs.sv
module lict_regs
   import lict_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [CNT_W-1:0]     wr_data,
   input  logic [1:0]           rd_addr,
   input  logic [CNT_W-1:0]     cur_count,
   output logic [CNT_W-1:0]     rd_data,
   output logic [VEC_W-1:0]     vec_q,
   output logic                 mask_q,
   output logic                 per_q,
   output logic [CNT_W-1:0]     init_q,
   output logic [SHIFT_W-1:0]   shift_q,
   output logic                 load_stb
);
   logic [DIV_W-1:0] div_q;
   logic             wr_entry, wr_div;

   assign wr_entry = wr_en && (wr_addr == REG_ENTRY);
   assign wr_div   = wr_en && (wr_addr == REG_DIV);
   assign load_stb = wr_en && (wr_addr == REG_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         mask_q <= 1'b1;
         per_q  <= 1'b0;
      end else if (wr_entry) begin
         vec_q  <= wr_data[VEC_W-1:0];
         mask_q <= wr_data[ENTRY_MASK_BIT];
         per_q  <= wr_data[ENTRY_PER_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        init_q <= '0;
      else if (load_stb) init_q <= wr_data;
   end

   // shift is held apart from the code so reset can leave it at divide-by-one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         shift_q <= '0;
      end else if (wr_div) begin
         div_q   <= wr_data[DIV_W-1:0];
         shift_q <= div_to_shift(wr_data[DIV_W-1:0]);
      end
   end

   always_comb begin
      rd_data = '0;
      case (lict_reg_e'(rd_addr))
         REG_ENTRY: begin
            rd_data[VEC_W-1:0]     = vec_q;
            rd_data[ENTRY_MASK_BIT] = mask_q;
            rd_data[ENTRY_PER_BIT]  = per_q;
         end
         REG_INIT:  rd_data = init_q;
         REG_CUR:   rd_data = cur_count;
         REG_DIV:   rd_data[DIV_W-1:0] = div_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/lict_expiry.sv
module lict_expiry
   import lict_pkg::*;
#(
   parameter int TS_W  = 48,
   parameter int CNT_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TS_W-1:0]     now,
   input  logic                load_stb,
   input  logic [CNT_W-1:0]    load_cnt,
   input  logic [CNT_W-1:0]    init_q,
   input  logic [SHIFT_W-1:0]  shift_q,
   input  logic                per_q,
   output logic                fire,
   output logic [CNT_W-1:0]    cur_count
);
   localparam int PAD_W = TS_W - CNT_W;

   logic [TS_W-1:0] load_ts_q, next_q;
   logic            armed_q;
   logic [TS_W-1:0] delta, ticks, period, rem;
   logic [TS_W-1:0] stage [SHIFT_W+1];
   logic            due;

   assign delta    = now - load_ts_q;
   assign stage[0] = delta;

   // log-depth right shifter, one stage per shift bit
   for (genvar i = 0; i < SHIFT_W; i++) begin : g_shift
      assign stage[i+1] = shift_q[i] ? (stage[i] >> (1 << i)) : stage[i];
   end

   assign ticks  = stage[SHIFT_W];
   assign period = {{PAD_W{1'b0}}, init_q} + TS_W'(1);
   assign due    = armed_q && (ticks >= next_q);
   // a reload in the same cycle wins over the old expiry
   assign fire   = due && !load_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_ts_q <= '0;
         next_q    <= '0;
         armed_q   <= 1'b0;
      end else if (load_stb) begin
         load_ts_q <= now;
         next_q    <= {{PAD_W{1'b0}}, load_cnt} + TS_W'(1);
         armed_q   <= (load_cnt != '0);
      end else if (due) begin
         if (per_q) next_q  <= next_q + period;
         else       armed_q <= 1'b0;
      end
   end

   assign rem = next_q - ticks - TS_W'(1);

   always_comb begin
      if (!armed_q || (ticks >= next_q))   cur_count = '0;
      else if (|rem[TS_W-1:CNT_W])         cur_count = '1;
      else                                 cur_count = rem[CNT_W-1:0];
   end
endmodule

// File: rtl/lict_irq_out.sv
module lict_irq_out #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             mask_q,
   input  logic [VEC_W-1:0] vec_q,
   output logic             irq_valid,
   output logic [VEC_W-1:0] irq_vector
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_valid <= fire && !mask_q;
         if (fire) irq_vector <= vec_q;
      end
   end
endmodule

// File: rtl/lict_timer.sv
module lict_timer
   import lict_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int TS_W  = 48,
   parameter int VEC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [1:0]        rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              irq_valid,
   output logic [VEC_W-1:0]  irq_vector
);
   if (CNT_W < ENTRY_PER_BIT + 1 || CNT_W > 64) begin : g_bad_cnt
      $error("lict_timer: CNT_W must lie in 18..64");
   end
   if (TS_W <= CNT_W) begin : g_bad_ts
      $error("lict_timer: TS_W must exceed CNT_W");
   end
   if (VEC_W < 1 || VEC_W > ENTRY_MASK_BIT) begin : g_bad_vec
      $error("lict_timer: VEC_W must lie in 1..16");
   end

   logic [TS_W-1:0]    now;
   logic [VEC_W-1:0]   vec_q;
   logic               mask_q, per_q, load_stb, fire;
   logic [CNT_W-1:0]   init_q, cur_count;
   logic [SHIFT_W-1:0] shift_q;

   lict_timebase #(.TS_W(TS_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .now(now)
   );

   lict_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .cur_count(cur_count), .rd_data(rd_data),
      .vec_q(vec_q), .mask_q(mask_q), .per_q(per_q),
      .init_q(init_q), .shift_q(shift_q), .load_stb(load_stb)
   );

   lict_expiry #(.TS_W(TS_W), .CNT_W(CNT_W)) u_exp (
      .clk(clk), .rst_n(rst_n), .now(now),
      .load_stb(load_stb), .load_cnt(wr_data),
      .init_q(init_q), .shift_q(shift_q), .per_q(per_q),
      .fire(fire), .cur_count(cur_count)
   );

   lict_irq_out #(.VEC_W(VEC_W)) u_out (
      .clk(clk), .rst_n(rst_n), .fire(fire), .mask_q(mask_q),
      .vec_q(vec_q), .irq_valid(irq_valid), .irq_vector(irq_vector)
   );
endmodule

// File: rtl/lict_timer_chk.sv
module lict_timer_chk #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic             irq_valid,
   input logic [VEC_W-1:0] irq_vector,
   input logic [VEC_W-1:0] vec_q,
   input logic             mask_q,
   input logic [CNT_W-1:0] init_q
);
   a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> !$past(mask_q));

   a_r4_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ($past(init_q) != '0));

   a_r5_vector_match: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_vector == $past(vec_q)));

   a_r9_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && (wr_addr == 2'd1)) |-> !irq_valid);
endmodule

bind lict_timer lict_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .irq_valid(irq_valid), .irq_vector(irq_vector),
   .vec_q(vec_q), .mask_q(mask_q), .init_q(init_q)
);

// File: tb/lict_timer_bench.sv
`timescale 1ns/1ps
module lict_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_valid;
   logic [7:0]  irq_vector;

   int n_chk = 0, n_fail = 0, cyc = 0, pulses = 0;
   int          exp_cyc[$];
   logic [7:0]  exp_vec[$];
   string       exp_req[$];

   localparam logic [31:0] PER  = 32'h0002_0000;
   localparam logic [31:0] MASK = 32'h0001_0000;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lict_timer u_lict_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && irq_valid) begin
         pulses++;
         if (exp_cyc.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R5 unexpected pulse: actual cycle %0d expected none", cyc);
         end else begin
            check(exp_req[0], "pulse cycle", cyc, exp_cyc[0]);
            check(exp_req[0], "pulse vector", irq_vector, exp_vec[0]);
            void'(exp_cyc.pop_front());
            void'(exp_vec.pop_front());
            void'(exp_req.pop_front());
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d, output int c);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      c = cyc;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic push(input int c, input logic [7:0] v, input string req);
      exp_cyc.push_back(c); exp_vec.push_back(v); exp_req.push_back(req);
   endtask

   task automatic wait_cyc(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic stop_drain(input string req);
      int c;
      wr(2'd1, 32'd0, c);
      repeat (3) @(negedge clk);
      check(req, "expected pulses left", exp_cyc.size(), 0);
   endtask

   task automatic run_periodic(input logic [3:0] dcode, input int sh, input int n,
                               input int np, input logic [7:0] v, input string req);
      int c0, p;
      wr(2'd3, {28'd0, dcode}, c0);
      wr(2'd0, PER | {24'd0, v}, c0);
      wr(2'd1, n, c0);
      p = (n + 1) << sh;
      for (int k = 1; k <= np; k++) push(c0 + k * p, v, req);
      wait_cyc(c0 + np * p);
      stop_drain(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int c0, c1, p0;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); check("R1", "entry", d, 32'h0001_0000);
      rd(2'd1, d); check("R1", "init", d, 0);
      rd(2'd2, d); check("R1", "current", d, 0);
      rd(2'd3, d); check("R1", "divide", d, 0);
      check("R1", "irq_valid", irq_valid, 0);

      // R5 periodic, divide by 1
      run_periodic(4'b1011, 0, 4, 3, 8'h31, "R5");
      // R2 divide settings
      run_periodic(4'b0001, 2, 2, 3, 8'h41, "R2");
      run_periodic(4'b0010, 3, 1, 2, 8'h42, "R2");
      run_periodic(4'b1010, 7, 1, 2, 8'h43, "R2");

      // R7 current count, shift 0
      wr(2'd3, 32'hB, c0);
      wr(2'd0, PER | 32'h40, c0);
      wr(2'd1, 9, c0);
      rd(2'd2, d); check("R7", "count j=0", d, 8);
      repeat (3) @(negedge clk);
      rd(2'd2, d); check("R7", "count j=3", d, 5);
      stop_drain("R7");
      // R7 current count, shift 7
      wr(2'd3, 32'hA, c0);
      wr(2'd1, 1, c0);
      rd(2'd2, d); check("R7", "count shift7 j=0", d, 1);
      repeat (200) @(negedge clk);
      rd(2'd2, d); check("R7", "count shift7 j=200", d, 0);
      stop_drain("R7");

      // R6 one-shot
      wr(2'd3, 32'hB, c0);
      wr(2'd0, 32'h22, c0);
      p0 = pulses;
      wr(2'd1, 6, c0);
      push(c0 + 7, 8'h22, "R6");
      wait_cyc(c0 + 40);
      check("R6", "one-shot pulse count", pulses - p0, 1);
      rd(2'd2, d); check("R6", "count after expiry", d, 0);
      // R10 current count is read-only
      wr(2'd2, 32'h1234, c0);
      rd(2'd1, d); check("R10", "init after write to addr 2", d, 6);
      rd(2'd2, d); check("R10", "current after write to addr 2", d, 0);

      // R4 zero count, both modes
      wr(2'd0, PER | 32'h55, c0);
      p0 = pulses;
      wr(2'd1, 0, c0);
      repeat (50) @(negedge clk);
      check("R4", "periodic zero pulses", pulses - p0, 0);
      wr(2'd0, 32'h56, c0);
      wr(2'd1, 0, c0);
      repeat (50) @(negedge clk);
      check("R4", "one-shot zero pulses", pulses - p0, 0);

      // R3 mask in mid-count, grid kept
      wr(2'd0, PER | 32'h66, c0);
      wr(2'd1, 9, c0);
      push(c0 + 10, 8'h66, "R3");
      push(c0 + 50, 8'h66, "R3");
      push(c0 + 60, 8'h66, "R3");
      wait_cyc(c0 + 12);
      wr(2'd0, PER | MASK | 32'h66, c1);
      rd(2'd0, d); check("R10", "entry readback", d, 32'h0003_0066);
      wait_cyc(c0 + 42);
      wr(2'd0, PER | 32'h66, c1);
      wait_cyc(c0 + 60);
      stop_drain("R3");

      // R8 reload mid-period
      wr(2'd0, PER | 32'h77, c0);
      wr(2'd1, 7, c0);
      wait_cyc(c0 + 4);
      wr(2'd1, 3, c1);
      push(c1 + 4, 8'h77, "R8");
      push(c1 + 8, 8'h77, "R8");
      wait_cyc(c1 + 8);
      stop_drain("R8");

      // R9 reload on the pulse edge
      wr(2'd0, PER | 32'h88, c0);
      wr(2'd1, 5, c0);
      p0 = pulses;
      wait_cyc(c0 + 5);
      wr(2'd1, 3, c1);
      check("R9", "reload edge cycle", c1, c0 + 6);
      push(c1 + 4, 8'h88, "R9");
      push(c1 + 8, 8'h88, "R9");
      wait_cyc(c1 + 8);
      stop_drain("R9");
      check("R9", "pulses after collision", pulses - p0, 2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule